// File: doc/BRIEF.md
# Dual-Channel Serial Port Host Register Front End

This block is the host side of two 16550-compatible serial channels that share one 8-bit bus. A host cycle is framed by active-low chip selects (one per channel), a 3-bit address, and active-low read and write strobes. None of these needs the serial clock. The block brings every bus input into the system clock domain. It holds each channel's line control, divisor and scratch registers and sends every access to the channel or channels that are selected.

Bit 7 of a channel's line control register opens the divisor latches at addresses 0 and 1. Suppose the whole divisor of a channel is zero. Then reading its high divisor byte returns the device identifier 0x12, and reading its low byte returns the revision code. Both channels can be selected for a write, which puts the same byte into both. Addresses whose registers this block does not hold are passed out as per-channel read and write strobes together with the address and write data. The baud generator, shift registers, FIFOs and interrupt logic attach there.

Top module: `dual_uart_regfront`

## Requirements
- R1: A write with only one channel selected (selAN or selBN low) changes only that channel's register at the given address.
- R2: A write with both selects low stores the byte at the addressed register of both channels.
- R3: A read with both selects low returns channel A's value.
- R4: Addresses 0 and 1 reach the low and high divisor bytes only when bit 7 of the line control register (address 3) is 1. Otherwise they are external addresses and do not change the divisor.
- R5: When a channel's divisor bytes are both 0x00 and its divisor is open, reading address 1 returns 0x12 and reading address 0 returns the revision code (0x01 by default). A nonzero divisor reads back its stored bytes.
- R6: After reset, line control reads 0x00, the divisor is 0x0000 and scratch (address 7) reads 0xFF in both channels, and rdData is 0x00.
- R7: Reset takes effect only after rstIn has been high on at least two consecutive clock edges. A pulse seen on one edge leaves every register unchanged.
- R8: A write commits exactly once, when the synchronized write strobe rises. Each write to an external address gives one single-cycle pulse on chWrStb for each selected channel.
- R9: rdData holds one value for as long as the synchronized read strobe stays low. It is 0x00 when no read is active and when a read has no channel selected.
- R10: Accesses to external addresses (2, 4, 5, 6, and 0/1 when the divisor is closed) pulse chRdStb or chWrStb of the channel reached and present the address on chAddr. Accesses to held registers pulse neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstIn | input | 1 | Active-high raw reset, qualified over two clocks |
| selAN | input | 1 | Channel A select, active low |
| selBN | input | 1 | Channel B select, active low |
| addr | input | 3 | Register address |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data |
| chRdStb | output | 2 | Per-channel read pulse for external addresses (bit 0 = A) |
| chWrStb | output | 2 | Per-channel write pulse for external addresses (bit 0 = A) |
| chAddr | output | 3 | Address of the last external access |
| chWrData | output | 8 | Data of the last write |

## Verification
Writes are driven with selA alone, selB alone and both selects together. Scratch values are then read back from each channel separately, which shows whether steering leaks into the other channel or drops a dual write. Reads with both selects, and reads with no select, show the defined fallback values. Divisor accesses are tried with the latch closed and open, with a zero divisor and with a nonzero one, and with the latch open only on channel B. This separates the identifier path from stored data and from external strobes. A one-edge reset pulse is followed by a long one, which tells the width qualification apart from a plain reset.

// File: rtl/dual_uart_regfront_pkg.sv
package dual_uart_regfront_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NCH = 2;

  typedef struct packed {
    logic            wrCommit;
    logic [NCH-1:0]  wrSel;
    logic [AW-1:0]   wrAddr;
    logic [DW-1:0]   wrData;
    logic            rdLoad;
    logic            rdLow;
    logic [NCH-1:0]  rdSel;
    logic [AW-1:0]   rdAddr;
  } busStb_t;
endpackage

// File: rtl/dual_uart_regfront_ctrl.sv
module dual_uart_regfront_ctrl
  import dual_uart_regfront_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_EDGES   = 2
) (
  input  logic          clk,
  input  logic          rstIn,
  input  logic          selAN,
  input  logic          selBN,
  input  logic [AW-1:0] addr,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [DW-1:0] wrData,
  output logic          rstInt,
  output busStb_t       stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [RST_EDGES-1:0] rstPipe;
  logic [SYNC_STAGES-1:0] rdPipe, wrPipe;
  logic [NCH-1:0] selPipe [SYNC_STAGES];
  logic [AW-1:0]  addrPipe [SYNC_STAGES];
  logic [DW-1:0]  dataPipe [SYNC_STAGES];
  logic rdPrev, wrPrev;
  logic [NCH-1:0] heldSel;
  logic [AW-1:0]  heldAddr;
  logic [DW-1:0]  heldData;
  logic rdSync, wrSync;

  // reset qualification: every stage must see the input high
  always_ff @(posedge clk) begin
    rstPipe <= {rstPipe[RST_EDGES-2:0], rstIn};
    rstInt  <= &rstPipe;
  end

  always_ff @(posedge clk) begin
    if (rstInt) begin
      rdPipe <= '1;
      wrPipe <= '1;
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      rdPipe <= {rdPipe[SYNC_STAGES-2:0], rdN};
      wrPipe <= {wrPipe[SYNC_STAGES-2:0], wrN};
      rdPrev <= rdPipe[LAST];
      wrPrev <= wrPipe[LAST];
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          selPipe[s]  <= {~selBN, ~selAN};
          addrPipe[s] <= addr;
          dataPipe[s] <= wrData;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          selPipe[s]  <= selPipe[s-1];
          addrPipe[s] <= addrPipe[s-1];
          dataPipe[s] <= dataPipe[s-1];
        end
      end
    end
  endgenerate

  assign rdSync = rdPipe[LAST];
  assign wrSync = wrPipe[LAST];

  // capture the write context while the strobe is still low
  always_ff @(posedge clk) begin
    if (rstInt) begin
      heldSel  <= '0;
      heldAddr <= '0;
      heldData <= '0;
    end else if (!wrSync) begin
      heldSel  <= selPipe[LAST];
      heldAddr <= addrPipe[LAST];
      heldData <= dataPipe[LAST];
    end
  end

  always_comb begin
    stb          = '0;
    stb.wrCommit = wrSync & ~wrPrev;
    stb.wrSel    = heldSel;
    stb.wrAddr   = heldAddr;
    stb.wrData   = heldData;
    stb.rdLoad   = ~rdSync & rdPrev;
    stb.rdLow    = ~rdSync;
    stb.rdSel    = selPipe[LAST];
    stb.rdAddr   = addrPipe[LAST];
  end
endmodule

// File: rtl/dual_uart_regfront_dp.sv
module dual_uart_regfront_dp
  import dual_uart_regfront_pkg::*;
#(
  parameter logic [DW-1:0] DEV_ID    = 8'h12,
  parameter logic [DW-1:0] DEV_REV   = 8'h01,
  parameter logic [DW-1:0] LCR_INIT  = 8'h00,
  parameter logic [DW-1:0] SCR_INIT  = 8'hFF,
  parameter logic [AW-1:0] ADDR_LCR  = 3'd3,
  parameter logic [AW-1:0] ADDR_SCR  = 3'd7,
  parameter int            LATCH_BIT = 7
) (
  input  logic           clk,
  input  logic           rstInt,
  input  busStb_t        stb,
  output logic [DW-1:0]  rdData,
  output logic [NCH-1:0] chRdStb,
  output logic [NCH-1:0] chWrStb,
  output logic [AW-1:0]  chAddr,
  output logic [DW-1:0]  chWrData
);
  logic [DW-1:0] lineCtl [NCH];
  logic [DW-1:0] divLo   [NCH];
  logic [DW-1:0] divHi   [NCH];
  logic [DW-1:0] scratch [NCH];
  logic [DW-1:0] chRead  [NCH];
  logic [NCH-1:0] wrHeld, rdHeld;
  logic [NCH-1:0] rdPick;

  function automatic logic isHeld(input logic [AW-1:0] a, input logic open);
    return (a == ADDR_LCR) || (a == ADDR_SCR) || (open && (a == 3'd0 || a == 3'd1));
  endfunction

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic latchOpen;
      logic divZero;
      assign latchOpen = lineCtl[c][LATCH_BIT];
      assign divZero   = (divLo[c] == '0) && (divHi[c] == '0);
      assign wrHeld[c] = isHeld(stb.wrAddr, latchOpen);
      assign rdHeld[c] = isHeld(stb.rdAddr, latchOpen);

      always_ff @(posedge clk) begin
        if (rstInt) begin
          lineCtl[c] <= LCR_INIT;
          divLo[c]   <= '0;
          divHi[c]   <= '0;
          scratch[c] <= SCR_INIT;
        end else if (stb.wrCommit && stb.wrSel[c]) begin
          if (stb.wrAddr == ADDR_LCR) lineCtl[c] <= stb.wrData;
          if (stb.wrAddr == ADDR_SCR) scratch[c] <= stb.wrData;
          if (latchOpen && stb.wrAddr == 3'd0) divLo[c] <= stb.wrData;
          if (latchOpen && stb.wrAddr == 3'd1) divHi[c] <= stb.wrData;
        end
      end

      always_comb begin
        chRead[c] = '0;
        if (stb.rdAddr == ADDR_LCR)
          chRead[c] = lineCtl[c];
        else if (stb.rdAddr == ADDR_SCR)
          chRead[c] = scratch[c];
        else if (latchOpen && stb.rdAddr == 3'd0)
          chRead[c] = divZero ? DEV_REV : divLo[c];
        else if (latchOpen && stb.rdAddr == 3'd1)
          chRead[c] = divZero ? DEV_ID : divHi[c];
      end
    end
  endgenerate

  // channel A wins a read with both selects
  always_comb begin
    rdPick = '0;
    if (stb.rdSel[0])      rdPick[0] = 1'b1;
    else if (stb.rdSel[1]) rdPick[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rstInt) begin
      rdData   <= '0;
      chRdStb  <= '0;
      chWrStb  <= '0;
      chAddr   <= '0;
      chWrData <= '0;
    end else begin
      chRdStb <= '0;
      chWrStb <= '0;
      if (!stb.rdLow) begin
        rdData <= '0;
      end else if (stb.rdLoad) begin
        rdData <= rdPick[0] ? chRead[0] : (rdPick[1] ? chRead[1] : '0);
        chRdStb <= rdPick & ~rdHeld;
        if ((rdPick & ~rdHeld) != '0) chAddr <= stb.rdAddr;
      end
      if (stb.wrCommit) begin
        chWrStb  <= stb.wrSel & ~wrHeld;
        chWrData <= stb.wrData;
        if ((stb.wrSel & ~wrHeld) != '0) chAddr <= stb.wrAddr;
      end
    end
  end
endmodule

// File: rtl/dual_uart_regfront.sv
module dual_uart_regfront
  import dual_uart_regfront_pkg::*;
#(
  parameter int            SYNC_STAGES = 2,
  parameter int            RST_EDGES   = 2,
  parameter logic [7:0]    DEV_ID      = 8'h12,
  parameter logic [7:0]    DEV_REV     = 8'h01,
  parameter logic [7:0]    SCR_INIT    = 8'hFF
) (
  input  logic       clk,
  input  logic       rstIn,
  input  logic       selAN,
  input  logic       selBN,
  input  logic [2:0] addr,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [1:0] chRdStb,
  output logic [1:0] chWrStb,
  output logic [2:0] chAddr,
  output logic [7:0] chWrData
);
  logic    rstInt;
  busStb_t stb;

  dual_uart_regfront_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .RST_EDGES  (RST_EDGES)
  ) u_ctrl (
    .clk   (clk),
    .rstIn (rstIn),
    .selAN (selAN),
    .selBN (selBN),
    .addr  (addr),
    .rdN   (rdN),
    .wrN   (wrN),
    .wrData(wrData),
    .rstInt(rstInt),
    .stb   (stb)
  );

  dual_uart_regfront_dp #(
    .DEV_ID  (DEV_ID),
    .DEV_REV (DEV_REV),
    .SCR_INIT(SCR_INIT)
  ) u_dp (
    .clk     (clk),
    .rstInt  (rstInt),
    .stb     (stb),
    .rdData  (rdData),
    .chRdStb (chRdStb),
    .chWrStb (chWrStb),
    .chAddr  (chAddr),
    .chWrData(chWrData)
  );
endmodule

// File: rtl/dual_uart_regfront_chk.sv
module dual_uart_regfront_chk (
  input logic       clk,
  input logic       rstIn,
  input logic       rstInt,
  input logic       rdLow,
  input logic       wrCommit,
  input logic [7:0] rdData,
  input logic [1:0] chRdStb,
  input logic [1:0] chWrStb
);
  int cyc = 0;
  always_ff @(posedge clk) if (cyc < 8) cyc <= cyc + 1;

  // R7: internal reset only after two consecutive high samples
  a_r7_reset_width: assert property (@(posedge clk) disable iff (cyc < 4)
    rstInt |-> ($past(rstIn, 2) && $past(rstIn, 3)));

  // R6: outputs are quiet right after reset
  a_r6_reset_quiet: assert property (@(posedge clk) disable iff (rstInt || cyc < 4)
    $fell(rstInt) |-> (rdData == 8'h00 && chWrStb == 2'b00 && chRdStb == 2'b00));

  // R8: write strobes are single-cycle and follow a commit
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rstInt || cyc < 4)
    (chWrStb != 2'b00) |=> (chWrStb == 2'b00));
  a_r8_after_commit: assert property (@(posedge clk) disable iff (rstInt || cyc < 4)
    (chWrStb != 2'b00) |-> $past(wrCommit));

  // R9: held stable during a read, zero when idle
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rstInt || cyc < 4)
    (rdLow && $past(rdLow) && $past(rdLow, 2)) |-> $stable(rdData));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rstInt || cyc < 4)
    (!rdLow && !$past(rdLow) && !$past(rstInt)) |-> (rdData == 8'h00));

  // R10: read strobes are single-cycle
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (rstInt || cyc < 4)
    (chRdStb != 2'b00) |=> (chRdStb == 2'b00));
endmodule

bind dual_uart_regfront dual_uart_regfront_chk u_chk (
  .clk     (clk),
  .rstIn   (rstIn),
  .rstInt  (rstInt),
  .rdLow   (stb.rdLow),
  .wrCommit(stb.wrCommit),
  .rdData  (rdData),
  .chRdStb (chRdStb),
  .chWrStb (chWrStb)
);

// File: tb/dual_uart_regfront_tb.sv
module dual_uart_regfront_tb;
  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic selAN = 1'b1, selBN = 1'b1;
  logic [2:0] addr = 3'd0;
  logic rdN = 1'b1, wrN = 1'b1;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, chWrData;
  logic [1:0] chRdStb, chWrStb;
  logic [2:0] chAddr;

  int checks = 0, errors = 0;
  int wrCnt [2];
  int rdCnt [2];
  bit finished = 0;

  // behavioural model state
  byte unsigned mLcr [2], mDll [2], mDlm [2], mScr [2];

  always #5 clk = ~clk;

  dual_uart_regfront u_dut (
    .clk(clk), .rstIn(rstIn), .selAN(selAN), .selBN(selBN), .addr(addr),
    .rdN(rdN), .wrN(wrN), .wrData(wrData), .rdData(rdData),
    .chRdStb(chRdStb), .chWrStb(chWrStb), .chAddr(chAddr), .chWrData(chWrData)
  );

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (chWrStb[c]) wrCnt[c]++;
      if (chRdStb[c]) rdCnt[c]++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int c = 0; c < 2; c++) begin
      mLcr[c] = 8'h00; mDll[c] = 8'h00; mDlm[c] = 8'h00; mScr[c] = 8'hFF;
    end
  endfunction

  function automatic bit modelHeld(input int c, input int a);
    return (a == 3) || (a == 7) || (mLcr[c][7] && (a == 0 || a == 1));
  endfunction

  function automatic int modelRead(input int c, input int a);
    bit zero = (mDll[c] == 0) && (mDlm[c] == 0);
    if (a == 3) return mLcr[c];
    if (a == 7) return mScr[c];
    if (mLcr[c][7] && a == 0) return zero ? 8'h01 : mDll[c];
    if (mLcr[c][7] && a == 1) return zero ? 8'h12 : mDlm[c];
    return 0;
  endfunction

  task automatic clearCounts();
    for (int c = 0; c < 2; c++) begin wrCnt[c] = 0; rdCnt[c] = 0; end
  endtask

  // mask bit0 = channel A, bit1 = channel B
  task automatic busWrite(input int mask, input int a, input int d, input string req);
    int expW [2];
    for (int c = 0; c < 2; c++)
      expW[c] = (mask[c] && !modelHeld(c, a)) ? 1 : 0;
    clearCounts();
    @(negedge clk);
    selAN = !mask[0]; selBN = !mask[1]; addr = a[2:0]; wrData = d[7:0];
    @(negedge clk); wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    repeat (5) @(negedge clk);
    selAN = 1'b1; selBN = 1'b1;
    for (int c = 0; c < 2; c++) begin
      if (mask[c]) begin
        if (a == 3) mLcr[c] = d[7:0];
        if (a == 7) mScr[c] = d[7:0];
        if (mLcr[c][7] && a == 0 && !(a == 3)) mDll[c] = d[7:0];
        if (mLcr[c][7] && a == 1) mDlm[c] = d[7:0];
      end
      check({req, " wrStb count"}, wrCnt[c], expW[c]);
    end
    if (expW[0] + expW[1] > 0) check({req, " chAddr"}, chAddr, a);
  endtask

  task automatic busRead(input int mask, input int a, input string req);
    int ch = mask[0] ? 0 : (mask[1] ? 1 : -1);
    int exp = (ch < 0) ? 0 : modelRead(ch, a);
    int expR = (ch >= 0 && !modelHeld(ch, a)) ? 1 : 0;
    clearCounts();
    @(negedge clk);
    selAN = !mask[0]; selBN = !mask[1]; addr = a[2:0];
    @(negedge clk); rdN = 1'b0;
    repeat (4) @(negedge clk);
    check({req, " rdData"}, rdData, exp);
    repeat (3) @(negedge clk);
    check({req, " R9 held"}, rdData, exp);
    check({req, " R10 rdStb count"}, rdCnt[ch < 0 ? 0 : ch], ch < 0 ? 0 : expR);
    rdN = 1'b1;
    repeat (4) @(negedge clk);
    check({req, " R9 idle zero"}, rdData, 0);
    selAN = 1'b1; selBN = 1'b1;
  endtask

  initial begin
    modelReset();
    repeat (5) @(negedge clk);
    rstIn = 1'b0;
    repeat (4) @(negedge clk);

    // R6 reset state
    check("R6 idle rdData", rdData, 0);
    busRead(1, 3, "R6 A lcr");
    busRead(1, 7, "R6 A scr");
    busRead(2, 7, "R6 B scr");

    // R1 single-channel write
    busWrite(1, 7, 8'h5A, "R1 A scr");
    busRead(1, 7, "R1 A scr");
    busRead(2, 7, "R1 B scr untouched");

    // R2 dual write
    busWrite(3, 7, 8'hC3, "R2 both scr");
    busRead(1, 7, "R2 A scr");
    busRead(2, 7, "R2 B scr");

    // R3 dual read returns A
    busWrite(2, 7, 8'h77, "R3 B scr");
    busRead(3, 7, "R3 dual read");
    busRead(2, 7, "R3 B scr");

    // R4 / R10 closed latch: address 0 is external
    busRead(1, 0, "R4 R10 A addr0 closed");
    busWrite(1, 0, 8'h99, "R4 R10 A addr0 closed write");

    // R5 zero divisor reads id and revision
    busWrite(1, 3, 8'h83, "R4 A open latch");
    busRead(1, 0, "R5 A rev");
    busRead(1, 1, "R5 A id");
    busWrite(1, 0, 8'h34, "R10 A dll held");
    busRead(1, 0, "R5 A dll stored");
    busRead(1, 1, "R5 A dlm stored zero");
    busWrite(1, 0, 8'h00, "R5 A dll clear");
    busRead(1, 1, "R5 A id again");

    // R4 channel B latch only
    busWrite(2, 0, 8'h55, "R4 B closed addr0");
    busWrite(2, 3, 8'h80, "R4 B open latch");
    busRead(2, 0, "R4 B dll untouched rev");
    busWrite(2, 1, 8'h02, "R4 B dlm");
    busRead(2, 1, "R4 B dlm stored");
    busRead(1, 1, "R1 A unaffected by B");

    // R9 no select, R8 dual external write
    busRead(0, 7, "R9 no select");
    busWrite(3, 2, 8'hE1, "R8 both external");
    check("R8 chWrData", chWrData, 8'hE1);

    // R7 short reset pulse ignored
    @(negedge clk); rstIn = 1'b1;
    @(negedge clk); rstIn = 1'b0;
    repeat (4) @(negedge clk);
    busRead(1, 7, "R7 short pulse scr kept");
    busRead(1, 3, "R7 short pulse lcr kept");

    // R6 R7 long reset
    @(negedge clk); rstIn = 1'b1;
    repeat (3) @(negedge clk); rstIn = 1'b0;
    modelReset();
    repeat (4) @(negedge clk);
    busRead(1, 7, "R6 R7 A scr reset");
    busRead(2, 3, "R6 R7 B lcr reset");
    busWrite(3, 3, 8'h80, "R6 open latch");
    busRead(2, 0, "R6 B divisor zero rev");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule